// File: doc/BRIEF.md
# Register File with Dedicated Registers

This block is the sixteen-entry, sixteen-bit register store of a small RISC processor core. It offers one write port and two combinational read ports, so a register-to-register operation can fetch both operands and have its result written back within a single clock. The lowest four entries have fixed jobs. Entry 0 holds the program counter and entry 1 the stack pointer. Entry 2 holds the status word. Entry 3 holds no data and instead supplies constants. Entries 4 through 15 are free for general use.

Read port A is the source-operand port and carries a 2-bit addressing-mode code. When port A selects entry 2 or entry 3, the code can make the port return a hardware constant in place of the stored value. Read port B is the destination-operand port and always returns stored contents. Writes can be a full word or a byte. The program counter and the status word are also driven out on their own ports for the rest of the core.

Instruction decoding, the ALU and flag generation sit outside this block.

Top module: `cpu_regfile`

## Requirements
- R1: While reset (rst_n low) is asserted, every entry is cleared. After reset, `pc_o`, `sr_o` and the stored-value reads of every entry return 0x0000.
- R2: A word write (`wr_byte`=0) stores all 16 bits of `wr_data` into entries 2 and 4 to 15. Once the clock edge has passed, the value can be read on either port; for a general-purpose entry the mode code on port A does not matter.
- R3: A byte write (`wr_byte`=1) stores `wr_data[7:0]` in bits 7:0 of the target entry and clears bits 15:8.
- R4: Any write to entry 0 or entry 1 stores bit 0 as 0, whatever `wr_data[0]` is.
- R5: A write to entry 3 has no effect. Port B reads of entry 3 always return 0x0000.
- R6: Port A reads of entry 3 return a value set by `rd_a_mode`: 0 gives 0x0000, 1 gives 0x0001, 2 gives 0x0002 and 3 gives 0xFFFF.
- R7: Port A reads of entry 2 depend on `rd_a_mode`. Mode 0 returns the stored status word. Mode 1 returns 0x0000, mode 2 returns 0x0004 and mode 3 returns 0x0008.
- R8: If a read selects the entry being written in the same cycle, it returns the value that will be stored, after byte and alignment formatting. The exception is when port A returns a constant: in that case the constant wins.
- R9: `pc_o` always shows the stored contents of entry 0, and `sr_o` always shows the stored contents of entry 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Entry number to write |
| wr_byte | input | 1 | 1 = byte write, 0 = word write |
| wr_data | input | 16 | Write data |
| rd_a_idx | input | 4 | Entry number for source read port |
| rd_a_mode | input | 2 | Addressing-mode code for port A (0 register, 1 indexed, 2 indirect, 3 indirect autoincrement) |
| rd_a_data | output | 16 | Source read data or generated constant |
| rd_b_idx | input | 4 | Entry number for destination read port |
| rd_b_data | output | 16 | Destination read data |
| pc_o | output | 16 | Program counter contents |
| sr_o | output | 16 | Status word contents |

## Verification
The hardest case to reach is a single cycle in which a write to entry 2 competes with a port A read of entry 2 in a non-zero mode. Here the constant must beat the forwarded write data, while port B in the same cycle must show the forwarded value. The stimulus table builds exactly this situation: it writes the status word with port A set to indirect mode and port B on the same entry, then reads the stored status word back to prove the write still landed. The other cases covered are forwarded byte writes and a write to entry 3 read on both ports in the same cycle.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    // Addressing-mode code that the source read port receives
    typedef enum logic [1:0] {
        AM_REG = 2'd0,
        AM_IDX = 2'd1,
        AM_IND = 2'd2,
        AM_INC = 2'd3
    } amode_e;

    // Entries with fixed roles
    localparam int IDX_PC = 0;
    localparam int IDX_SP = 1;
    localparam int IDX_SR = 2;
    localparam int IDX_CG = 3;

endpackage

// File: rtl/regfile_wr_fmt.sv
module regfile_wr_fmt
    import regfile_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 4
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic          wr_byte,
    input  logic [DW-1:0] wr_data,
    output logic          commit,
    output logic [DW-1:0] fmt_data
);
    localparam int HALF = DW / 2;

    logic is_ptr;
    logic is_cg;

    always_comb begin
        is_cg  = (wr_idx == AW'(IDX_CG));
        is_ptr = (wr_idx == AW'(IDX_PC)) || (wr_idx == AW'(IDX_SP));
        commit = wr_en && !is_cg;

        if (wr_byte) begin
            fmt_data = {{(DW-HALF){1'b0}}, wr_data[HALF-1:0]};
        end else begin
            fmt_data = wr_data;
        end

        if (is_ptr) begin
            fmt_data[0] = 1'b0;
        end
    end

endmodule

// File: rtl/regfile_store.sv
module regfile_store
    import regfile_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 16,
    parameter int AW   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  logic [AW-1:0]             wr_idx,
    input  logic [DW-1:0]             fmt_data,
    output logic [NREG-1:0][DW-1:0]   regs_o
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } store_t;

    store_t st_d;
    store_t st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (commit && (wr_idx == AW'(i)) && (i != IDX_CG)) begin
                st_d.regs[i] = fmt_data;
            end
        end
        st_d.regs[IDX_CG] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;

    AST_CG_SLOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.regs[IDX_CG] == '0); // R5

endmodule

// File: rtl/regfile_rd_port.sv
module regfile_rd_port
    import regfile_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 16,
    parameter int AW   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREG-1:0][DW-1:0] regs,
    input  logic [AW-1:0]           rd_idx,
    input  logic [1:0]              rd_mode,
    input  logic                    commit,
    input  logic [AW-1:0]           wr_idx,
    input  logic [DW-1:0]           fmt_data,
    output logic [DW-1:0]           rd_data
);
    amode_e          mode;
    logic [DW-1:0]   stored;
    logic [DW-1:0]   cg1_val;
    logic [DW-1:0]   cg2_val;
    logic            fwd_hit;

    always_comb begin
        mode    = amode_e'(rd_mode);
        fwd_hit = commit && (wr_idx == rd_idx);
        stored  = fwd_hit ? fmt_data : regs[rd_idx];

        unique case (mode)
            AM_REG:  cg2_val = '0;
            AM_IDX:  cg2_val = DW'(1);
            AM_IND:  cg2_val = DW'(2);
            default: cg2_val = '1;
        endcase

        unique case (mode)
            AM_REG:  cg1_val = stored;
            AM_IDX:  cg1_val = '0;
            AM_IND:  cg1_val = DW'(4);
            default: cg1_val = DW'(8);
        endcase

        if (rd_idx == AW'(IDX_CG)) begin
            rd_data = cg2_val;
        end else if (rd_idx == AW'(IDX_SR)) begin
            rd_data = cg1_val;
        end else begin
            rd_data = stored;
        end
    end

    AST_CG2_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == AW'(IDX_CG)) && (rd_mode == 2'd3) |-> rd_data == '1); // R6

    AST_CG2_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == AW'(IDX_CG)) && (rd_mode == 2'd0) |-> rd_data == '0); // R6

    AST_CG1_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx == AW'(IDX_SR)) && (rd_mode == 2'd2) |-> rd_data == DW'(4)); // R7

    AST_GP_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        commit && (wr_idx == rd_idx) && (rd_idx > AW'(IDX_CG)) |-> rd_data == fmt_data); // R8

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import regfile_pkg::*;
#(
    parameter  int DW   = 16,
    parameter  int NREG = 16,
    localparam int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic          wr_byte,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [1:0]    rd_a_mode,
    output logic [DW-1:0] rd_a_data,
    input  logic [AW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_b_data,
    output logic [DW-1:0] pc_o,
    output logic [DW-1:0] sr_o
);
    localparam int HALF = DW / 2;

    logic                    commit;
    logic [DW-1:0]           fmt_data;
    logic [NREG-1:0][DW-1:0] regs;

    regfile_wr_fmt #(.DW(DW), .AW(AW)) u_fmt (
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_byte  (wr_byte),
        .wr_data  (wr_data),
        .commit   (commit),
        .fmt_data (fmt_data)
    );

    regfile_store #(.DW(DW), .NREG(NREG), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .wr_idx   (wr_idx),
        .fmt_data (fmt_data),
        .regs_o   (regs)
    );

    // Source port: mode code selects constants for entries 2 and 3
    regfile_rd_port #(.DW(DW), .NREG(NREG), .AW(AW)) u_rd_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .regs     (regs),
        .rd_idx   (rd_a_idx),
        .rd_mode  (rd_a_mode),
        .commit   (commit),
        .wr_idx   (wr_idx),
        .fmt_data (fmt_data),
        .rd_data  (rd_a_data)
    );

    // Destination port: register mode fixed, so stored contents come back
    regfile_rd_port #(.DW(DW), .NREG(NREG), .AW(AW)) u_rd_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .regs     (regs),
        .rd_idx   (rd_b_idx),
        .rd_mode  (2'd0),
        .commit   (commit),
        .wr_idx   (wr_idx),
        .fmt_data (fmt_data),
        .rd_data  (rd_b_data)
    );

    assign pc_o = regs[IDX_PC];
    assign sr_o = regs[IDX_SR];

    AST_PC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[0] == 1'b0); // R4

    AST_SP_WRITE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_idx == AW'(IDX_SP)) && (rd_b_idx == AW'(IDX_SP)) |-> rd_b_data[0] == 1'b0); // R4

    AST_BYTE_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_byte && (wr_idx == AW'(IDX_PC)) |=> pc_o[DW-1:HALF] == '0); // R3

    AST_SR_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_byte && (wr_idx == AW'(IDX_SR)) |=> sr_o == $past(wr_data)); // R2

    AST_CG_PORT_B_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx == AW'(IDX_CG)) |-> rd_b_data == '0); // R5

endmodule

// File: tb/sim_cpu_regfile.sv
module sim_cpu_regfile;
    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic        wr_byte = 1'b0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rd_a_idx = '0;
    logic [1:0]  rd_a_mode = '0;
    logic [15:0] rd_a_data;
    logic [3:0]  rd_b_idx = '0;
    logic [15:0] rd_b_data;
    logic [15:0] pc_o;
    logic [15:0] sr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    cpu_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte), .wr_data(wr_data),
        .rd_a_idx(rd_a_idx), .rd_a_mode(rd_a_mode), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .pc_o(pc_o), .sr_o(sr_o)
    );

    typedef struct packed {
        logic        we;
        logic [3:0]  wi;
        logic        wb;
        logic [15:0] wd;
        logic [3:0]  ai;
        logic [1:0]  am;
        logic [3:0]  bi;
        logic [15:0] ea;
        logic [15:0] eb;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd5,  1'b0, 16'h1234, 4'd5,  2'd0, 4'd5,  16'h1234, 16'h1234, 4'd8}, // R8 forward word
        '{1'b0, 4'd0,  1'b0, 16'h0000, 4'd5,  2'd1, 4'd5,  16'h1234, 16'h1234, 4'd2}, // R2 stored, mode ignored
        '{1'b1, 4'd6,  1'b1, 16'hABCD, 4'd6,  2'd0, 4'd5,  16'h00CD, 16'h1234, 4'd3}, // R3 forwarded byte
        '{1'b0, 4'd0,  1'b0, 16'h0000, 4'd6,  2'd0, 4'd6,  16'h00CD, 16'h00CD, 4'd3}, // R3 stored byte
        '{1'b1, 4'd0,  1'b0, 16'h1235, 4'd0,  2'd0, 4'd1,  16'h1234, 16'h0000, 4'd4}, // R4 pc bit0
        '{1'b1, 4'd1,  1'b0, 16'hFFFF, 4'd1,  2'd0, 4'd0,  16'hFFFE, 16'h1234, 4'd4}, // R4 sp bit0
        '{1'b1, 4'd3,  1'b0, 16'h5555, 4'd3,  2'd0, 4'd3,  16'h0000, 16'h0000, 4'd5}, // R5 write to cg
        '{1'b0, 4'd0,  1'b0, 16'h0000, 4'd3,  2'd1, 4'd3,  16'h0001, 16'h0000, 4'd6}, // R6 mode 1
        '{1'b0, 4'd0,  1'b0, 16'h0000, 4'd3,  2'd2, 4'd1,  16'h0002, 16'hFFFE, 4'd6}, // R6 mode 2
        '{1'b0, 4'd0,  1'b0, 16'h0000, 4'd3,  2'd3, 4'd2,  16'hFFFF, 16'h0000, 4'd6}, // R6 mode 3
        '{1'b1, 4'd2,  1'b0, 16'h00F7, 4'd2,  2'd0, 4'd2,  16'h00F7, 16'h00F7, 4'd7}, // R7 mode 0 forwarded
        '{1'b0, 4'd0,  1'b0, 16'h0000, 4'd2,  2'd1, 4'd2,  16'h0000, 16'h00F7, 4'd7}, // R7 mode 1
        '{1'b0, 4'd0,  1'b0, 16'h0000, 4'd2,  2'd2, 4'd15, 16'h0004, 16'h0000, 4'd7}, // R7 mode 2
        '{1'b0, 4'd0,  1'b0, 16'h0000, 4'd2,  2'd3, 4'd6,  16'h0008, 16'h00CD, 4'd7}, // R7 mode 3
        '{1'b1, 4'd2,  1'b0, 16'h1111, 4'd2,  2'd2, 4'd2,  16'h0004, 16'h1111, 4'd8}, // R8 constant beats forward
        '{1'b1, 4'd15, 1'b1, 16'hFF80, 4'd15, 2'd3, 4'd15, 16'h0080, 16'h0080, 4'd3}  // R3 byte on top entry
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic we, input logic [3:0] wi, input logic wb, input logic [15:0] wd,
                         input logic [3:0] ai, input logic [1:0] am, input logic [3:0] bi);
        wr_en = we; wr_idx = wi; wr_byte = wb; wr_data = wd;
        rd_a_idx = ai; rd_a_mode = am; rd_b_idx = bi;
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state, R1
        repeat (3) @(posedge clk);
        @(negedge clk);
        drive(1'b0, 4'd0, 1'b0, 16'h0, 4'd9, 2'd0, 4'd4);
        #1;
        check("R1 reset pc", pc_o, 16'h0000);
        check("R1 reset sr", sr_o, 16'h0000);
        check("R1 reset r9", rd_a_data, 16'h0000);
        check("R1 reset r4", rd_b_data, 16'h0000);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].we, VECS[i].wi, VECS[i].wb, VECS[i].wd, VECS[i].ai, VECS[i].am, VECS[i].bi);
            #1;
            check($sformatf("R%0d vec %0d port A", VECS[i].rq, i), rd_a_data, VECS[i].ea);
            check($sformatf("R%0d vec %0d port B", VECS[i].rq, i), rd_b_data, VECS[i].eb);
        end

        // Direct outputs, R9
        @(negedge clk);
        drive(1'b0, 4'd0, 1'b0, 16'h0, 4'd4, 2'd0, 4'd4);
        #1;
        check("R9 pc_o", pc_o, 16'h1234);
        check("R9 sr_o", sr_o, 16'h1111);

        // Byte write to program counter: R3 and R4
        @(negedge clk);
        drive(1'b1, 4'd0, 1'b1, 16'hA5FF, 4'd4, 2'd0, 4'd4);
        @(negedge clk);
        drive(1'b1, 4'd1, 1'b0, 16'h8001, 4'd4, 2'd0, 4'd4);
        #1;
        check("R4 pc byte write", pc_o, 16'h00FE);
        @(negedge clk);
        drive(1'b0, 4'd0, 1'b0, 16'h0, 4'd1, 2'd0, 4'd1);
        #1;
        check("R4 sp word write port B", rd_b_data, 16'h8000);
        check("R4 sp word write port A", rd_a_data, 16'h8000);

        // Reset mid-run, R1
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 4'd0, 1'b0, 16'h0, 4'd6, 2'd0, 4'd5);
        @(posedge clk);
        #1;
        check("R1 rerun pc", pc_o, 16'h0000);
        check("R1 rerun sr", sr_o, 16'h0000);
        check("R1 rerun r6", rd_a_data, 16'h0000);
        check("R1 rerun r5", rd_b_data, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule